// File: doc/BRIEF.md
# Synchronous Half-Duplex Parity Serial Transceiver

This block is the master end of a two-wire synchronous serial link. It produces the link clock on a pin of its own and shares one bidirectional data wire with the far end. Characters travel in 12-bit frames with even parity. The block shifts outgoing bits onto the wire when the link clock falls. It samples incoming bits when the link clock rises. It switches the data driver off and on as the direction of transfer changes.

A host brings the link up with a one-cycle enable request. The block then holds the data line high for a guard interval and starts the link clock. It sends two all-ones idle frames and then reports the link as up. After that the host can send a byte through a valid/ready pair, request an idle (break) frame, or request reception of one byte. A received byte is reported with a one-cycle valid flag and an error flag. A disable request stops the clock and releases both wires.

Top module: `sync_parity_xcvr`

## Requirements
- R1: A transmitted byte is sent as 12 bits, least significant first, one bit per link clock period. Bit 0 is a start bit at 0, bits 1 to 8 are the data, bit 9 is parity, and bits 10 and 11 are stop bits at 1. The far end reads each bit at a rising edge of `lnk_clk_o`.
- R2: The parity bit (frame bit 9) equals the XOR of the eight data bits.
- R3: While `lnk_clk_oe` is high and the clock is running, `lnk_clk_o` toggles every `CLK_DIV` system cycles. It keeps toggling while no frame is in flight.
- R4: While the data driver stays enabled, `lnk_dat_o` changes only in the system cycle in which `lnk_clk_o` falls.
- R5: When receiving, the block samples `lnk_dat_i` at rising link clock edges. It starts a frame only on a sampled 0, and any number of high samples before that are ignored. `rx_data` is frame bits 1 to 8.
- R6: `rx_valid` is high for exactly one cycle per received frame. `rx_err` is high in that cycle if and only if the parity bit differs from the XOR of the data bits or either stop bit is 0.
- R7: A break request sends one frame period of all ones, with no start bit, and `tx_ready` stays low while the break is in progress.
- R8: `tx_ready` is high only while the link is up and no frame, break or reception is in progress. Send, break and receive requests are taken only while `tx_ready` is high.
- R9: A receive request is taken only after the previous transmit frame has ended. From the next cycle on, `lnk_dat_oe` is 0 and `lnk_dat_o` is 0.
- R10: Going from receive back to transmit, `lnk_dat_o` is set to 1 one cycle before `lnk_dat_oe` rises.
- R11: The cycle after an enable request, both output enables are 1 and `lnk_dat_o` is 1. `lnk_clk_o` stays low for at least `GUARD_CYCLES` cycles. Then the clock starts and at least 24 high bits and no start bit are sent before `link_up` and `tx_ready` rise.
- R12: The cycle after a disable request, `lnk_clk_o`, `lnk_clk_oe`, `lnk_dat_o`, `lnk_dat_oe` and `link_up` are all 0, and the clock stays stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en_req | input | 1 | One-cycle request to bring the link up |
| dis_req | input | 1 | One-cycle request to shut the link down (taken when idle) |
| brk_req | input | 1 | Request one all-ones idle frame |
| tx_valid | input | 1 | Byte to send is valid |
| tx_data | input | 8 | Byte to send |
| tx_ready | output | 1 | Block accepts a send, break or receive request |
| rx_req | input | 1 | Request reception of one byte |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| rx_err | output | 1 | Parity or stop bit error on the frame in `rx_data` |
| link_up | output | 1 | Link enable sequence finished |
| lnk_clk_o | output | 1 | Link clock output value |
| lnk_clk_oe | output | 1 | Link clock driver enable |
| lnk_dat_o | output | 1 | Data line output value |
| lnk_dat_oe | output | 1 | Data line driver enable |
| lnk_dat_i | input | 1 | Data line input value |

## Verification
Transmission is tried with random bytes from a fixed seed and with the bytes 00, FF, 01 and 80. These cases separate a wrong bit order or a missing parity bit from correct framing, because they give parity of both polarities and set only the end bits. Reception is tried with random well-formed frames preceded by a random number of idle high bits, which shows whether the block waits for a start bit. It is also tried with frames that have a bad parity bit or a low first or second stop bit, which shows that each error source on its own raises the error flag. Direction changes in both ways, a break, and a disable followed by a re-enable check the line control and the clock behaviour around the frame engine.

// File: rtl/sxc_pkg.sv
// Shared types for the synchronous parity transceiver.
package sxc_pkg;
    // Link sequencer states; ordering is not relied on anywhere.
    typedef enum logic [2:0] {
        ST_OFF,
        ST_GUARD,
        ST_BRK1,
        ST_BRK2,
        ST_IDLE,
        ST_TURN,
        ST_TX,
        ST_RX
    } link_state_t;
endpackage

// File: rtl/sxc_clkgen.sv
// Link clock generator.
// Divides the system clock so that the link clock toggles once every
// CLK_DIV system cycles while run is high. It emits one-cycle rise/fall
// event strobes in the cycle whose edge makes the pin change.
// Assumes CLK_DIV >= 2. While run is low the pin is held at 0.
module sxc_clkgen #(
    parameter int CLK_DIV = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic lclk,
    output logic rise_evt,
    output logic fall_evt
);
    localparam int CW = $clog2(CLK_DIV);

    logic [CW-1:0] div_q;
    logic          term;

    // Terminal count of the divider marks a pin toggle at the next edge.
    always_comb begin
        term     = run && (div_q == CW'(CLK_DIV - 1));
        rise_evt = term && !lclk;
        fall_evt = term && lclk;
    end

    // Divider counter and pin toggle register.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            div_q <= '0;
            lclk  <= 1'b0;
        end else if (term) begin
            div_q <= '0;
            lclk  <= ~lclk;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end
endmodule

// File: rtl/sxc_shift.sv
// Frame shift engine.
// Transmit: on tx_load takes a FRAME_BITS word and, at each link clock fall,
// puts the next bit (LSB first) on the data output. It runs FRAME_BITS+1 falls
// so the last stop bit gets a full period; after that the line idles high.
// Receive: on rx_arm it waits for a sampled 0 at a rising event, then collects
// the rest of the frame and pulses rx_done for one cycle.
// line_lo/line_hi force the data output register (line_lo wins).
module sxc_shift #(
    parameter int FRAME_BITS = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rise_evt,
    input  logic                  fall_evt,
    input  logic                  tx_load,
    input  logic [FRAME_BITS-1:0] tx_word,
    input  logic                  rx_arm,
    input  logic                  line_hi,
    input  logic                  line_lo,
    input  logic                  dat_i,
    output logic                  dat_o,
    output logic                  tx_busy,
    output logic                  rx_busy,
    output logic [FRAME_BITS-1:0] rx_word,
    output logic                  rx_done
);
    localparam int TCW = $clog2(FRAME_BITS + 2);
    localparam int RCW = $clog2(FRAME_BITS + 1);

    logic [FRAME_BITS-1:0] tx_sh;
    logic [TCW-1:0]        tx_cnt;
    logic [RCW-1:0]        rx_cnt;
    logic                  rx_wait;

    // Busy flags derived from the bit counters.
    always_comb begin
        tx_busy = (tx_cnt != '0);
        rx_busy = rx_wait || (rx_cnt != '0);
    end

    // Transmit shift register, bit counter and data output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sh  <= '1;
            tx_cnt <= '0;
            dat_o  <= 1'b0;
        end else begin
            if (tx_load) begin
                tx_sh  <= tx_word;
                tx_cnt <= TCW'(FRAME_BITS + 1);
            end else if (fall_evt && tx_busy) begin
                tx_sh  <= {1'b1, tx_sh[FRAME_BITS-1:1]};
                tx_cnt <= tx_cnt - 1'b1;
            end
            if (line_lo) begin
                dat_o <= 1'b0;
            end else if (line_hi) begin
                dat_o <= 1'b1;
            end else if (!tx_load && fall_evt && tx_busy) begin
                dat_o <= tx_sh[0];
            end
        end
    end

    // Receive start detection, shift register and completion strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_wait <= 1'b0;
            rx_cnt  <= '0;
            rx_word <= '0;
            rx_done <= 1'b0;
        end else begin
            rx_done <= 1'b0;
            if (rx_arm) begin
                rx_wait <= 1'b1;
                rx_cnt  <= '0;
            end else if (rise_evt) begin
                if (rx_wait && !dat_i) begin
                    rx_wait <= 1'b0;
                    rx_cnt  <= RCW'(FRAME_BITS - 1);
                    rx_word <= {dat_i, rx_word[FRAME_BITS-1:1]};
                end else if (rx_cnt != '0) begin
                    rx_word <= {dat_i, rx_word[FRAME_BITS-1:1]};
                    rx_cnt  <= rx_cnt - 1'b1;
                    if (rx_cnt == RCW'(1)) begin
                        rx_done <= 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/sxc_ctrl.sv
// Link sequencer.
// Runs the enable sequence (guard time with data high, clock start, two idle
// frames), accepts send/break/receive/disable requests only when idle, and
// handles the data line direction changes. Request priority when several are
// raised together: disable, break, send, receive.
// Strobes to the shift engine are combinational from state and requests.
module sxc_ctrl #(
    parameter int DATA_W       = 8,
    parameter int GUARD_CYCLES = 20,
    parameter int FRAME_BITS   = DATA_W + 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  en_req,
    input  logic                  dis_req,
    input  logic                  brk_req,
    input  logic                  tx_valid,
    input  logic [DATA_W-1:0]     tx_data,
    input  logic                  rx_req,
    input  logic                  tx_busy,
    input  logic                  rx_busy,
    output logic                  tx_ready,
    output logic                  link_up,
    output logic                  clk_run,
    output logic                  clk_oe,
    output logic                  dat_oe,
    output logic                  tx_load,
    output logic [FRAME_BITS-1:0] tx_word,
    output logic                  rx_arm,
    output logic                  line_hi,
    output logic                  line_lo
);
    import sxc_pkg::*;

    localparam int GW = $clog2(GUARD_CYCLES + 1);
    localparam logic [FRAME_BITS-1:0] IDLE_WORD = {FRAME_BITS{1'b1}};

    link_state_t           state;
    logic                  dir_rx;
    logic [GW-1:0]         gcnt;
    logic [FRAME_BITS-1:0] pend_q;
    logic                  idle, dis_take, brk_take, txd_take, rx_take, snd_take;
    logic                  guard_end, brk1_end;
    logic [FRAME_BITS-1:0] new_word;

    // Request arbitration and shift engine strobes.
    always_comb begin
        idle      = (state == ST_IDLE);
        dis_take  = idle && dis_req;
        brk_take  = idle && !dis_req && brk_req;
        txd_take  = idle && !dis_req && !brk_req && tx_valid;
        rx_take   = idle && !dis_req && !brk_req && !tx_valid && rx_req;
        snd_take  = brk_take || txd_take;
        new_word  = brk_take ? IDLE_WORD : {2'b11, ^tx_data, tx_data, 1'b0};
        guard_end = (state == ST_GUARD) && (gcnt == GW'(GUARD_CYCLES - 1));
        brk1_end  = (state == ST_BRK1) && !tx_busy;
        tx_load   = guard_end || brk1_end || (snd_take && !dir_rx) || (state == ST_TURN);
        if (guard_end || brk1_end) begin
            tx_word = IDLE_WORD;
        end else if (state == ST_TURN) begin
            tx_word = pend_q;
        end else begin
            tx_word = new_word;
        end
        rx_arm   = rx_take;
        line_hi  = ((state == ST_OFF) && en_req) || (snd_take && dir_rx);
        line_lo  = dis_take || (rx_take && !dir_rx);
        clk_run  = (state != ST_OFF) && (state != ST_GUARD) && !dis_take;
        tx_ready = idle;
        link_up  = (state == ST_IDLE) || (state == ST_TURN) || (state == ST_TX) || (state == ST_RX);
    end

    // Sequencer state, driver enables, direction and guard counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_OFF;
            dir_rx <= 1'b0;
            clk_oe <= 1'b0;
            dat_oe <= 1'b0;
            gcnt   <= '0;
            pend_q <= IDLE_WORD;
        end else begin
            case (state)
                ST_OFF: begin
                    if (en_req) begin
                        state  <= ST_GUARD;
                        clk_oe <= 1'b1;
                        dat_oe <= 1'b1;
                        dir_rx <= 1'b0;
                        gcnt   <= '0;
                    end
                end
                ST_GUARD: begin
                    gcnt <= gcnt + 1'b1;
                    if (guard_end) begin
                        state <= ST_BRK1;
                    end
                end
                ST_BRK1: begin
                    if (!tx_busy) begin
                        state <= ST_BRK2;
                    end
                end
                ST_BRK2: begin
                    if (!tx_busy) begin
                        state <= ST_IDLE;
                    end
                end
                ST_IDLE: begin
                    if (dis_take) begin
                        state  <= ST_OFF;
                        clk_oe <= 1'b0;
                        dat_oe <= 1'b0;
                    end else if (snd_take) begin
                        if (dir_rx) begin
                            pend_q <= new_word;
                            state  <= ST_TURN;
                        end else begin
                            state <= ST_TX;
                        end
                    end else if (rx_take) begin
                        dat_oe <= 1'b0;
                        dir_rx <= 1'b1;
                        state  <= ST_RX;
                    end
                end
                ST_TURN: begin
                    dat_oe <= 1'b1;
                    dir_rx <= 1'b0;
                    state  <= ST_TX;
                end
                ST_TX: begin
                    if (!tx_busy) begin
                        state <= ST_IDLE;
                    end
                end
                ST_RX: begin
                    if (!rx_busy) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_OFF;
            endcase
        end
    end
endmodule

// File: rtl/sync_parity_xcvr.sv
// Synchronous half-duplex parity serial transceiver, master side.
// Generates the link clock, frames bytes as start/8 data/even parity/2 stop,
// sends them on link clock falls, and samples received frames on link clock
// rises. Assumes the far end drives the data wire only while lnk_dat_oe is low,
// and that CLK_DIV >= 2 and GUARD_CYCLES >= 1.
module sync_parity_xcvr #(
    parameter int CLK_DIV      = 100,
    parameter int GUARD_CYCLES = 20,
    parameter int DATA_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_req,
    input  logic              dis_req,
    input  logic              brk_req,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_ready,
    input  logic              rx_req,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_err,
    output logic              link_up,
    output logic              lnk_clk_o,
    output logic              lnk_clk_oe,
    output logic              lnk_dat_o,
    output logic              lnk_dat_oe,
    input  logic              lnk_dat_i
);
    localparam int FRAME_BITS = DATA_W + 4;

    logic                  clk_run, rise_evt, fall_evt;
    logic                  tx_load, rx_arm, line_hi, line_lo;
    logic                  tx_busy, rx_busy, rx_done;
    logic [FRAME_BITS-1:0] tx_word, rx_word;

    sxc_ctrl #(
        .DATA_W      (DATA_W),
        .GUARD_CYCLES(GUARD_CYCLES),
        .FRAME_BITS  (FRAME_BITS)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_req  (en_req),
        .dis_req (dis_req),
        .brk_req (brk_req),
        .tx_valid(tx_valid),
        .tx_data (tx_data),
        .rx_req  (rx_req),
        .tx_busy (tx_busy),
        .rx_busy (rx_busy),
        .tx_ready(tx_ready),
        .link_up (link_up),
        .clk_run (clk_run),
        .clk_oe  (lnk_clk_oe),
        .dat_oe  (lnk_dat_oe),
        .tx_load (tx_load),
        .tx_word (tx_word),
        .rx_arm  (rx_arm),
        .line_hi (line_hi),
        .line_lo (line_lo)
    );

    sxc_clkgen #(
        .CLK_DIV(CLK_DIV)
    ) u_clkgen (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (clk_run),
        .lclk    (lnk_clk_o),
        .rise_evt(rise_evt),
        .fall_evt(fall_evt)
    );

    sxc_shift #(
        .FRAME_BITS(FRAME_BITS)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise_evt(rise_evt),
        .fall_evt(fall_evt),
        .tx_load (tx_load),
        .tx_word (tx_word),
        .rx_arm  (rx_arm),
        .line_hi (line_hi),
        .line_lo (line_lo),
        .dat_i   (lnk_dat_i),
        .dat_o   (lnk_dat_o),
        .tx_busy (tx_busy),
        .rx_busy (rx_busy),
        .rx_word (rx_word),
        .rx_done (rx_done)
    );

    // Receive result: data field, strobe, and parity/stop bit check.
    always_comb begin
        rx_data  = rx_word[DATA_W:1];
        rx_valid = rx_done;
        rx_err   = rx_done &&
                   (((^rx_word[DATA_W:1]) != rx_word[DATA_W+1]) ||
                    (rx_word[FRAME_BITS-1:FRAME_BITS-2] != 2'b11));
    end
endmodule

// File: rtl/sxc_checker.sv
// Protocol checker for sync_parity_xcvr, attached with bind.
// Watches only the top-level ports; keeps its own link clock period counter.
module sxc_checker #(
    parameter int CLK_DIV = 100
) (
    input logic clk,
    input logic rst_n,
    input logic tx_ready,
    input logic link_up,
    input logic rx_valid,
    input logic lnk_clk_o,
    input logic lnk_clk_oe,
    input logic lnk_dat_o,
    input logic lnk_dat_oe
);
    logic        prev_q;
    logic        seen_q;
    logic [31:0] since_q;

    // Cycles since the last observed link clock toggle, while the clock driver is on.
    always_ff @(posedge clk) begin
        prev_q <= lnk_clk_o;
        if (!rst_n || !lnk_clk_oe) begin
            since_q <= '0;
            seen_q  <= 1'b0;
        end else if (lnk_clk_o != prev_q) begin
            since_q <= 32'd1;
            seen_q  <= 1'b1;
        end else begin
            since_q <= since_q + 32'd1;
        end
    end

    AST_CLK_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (lnk_clk_oe && seen_q && (lnk_clk_o != prev_q)) |-> (since_q == 32'(CLK_DIV))); // R3

    AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (lnk_dat_oe && $past(lnk_dat_oe) && (lnk_dat_o != $past(lnk_dat_o))) |-> $fell(lnk_clk_o)); // R4

    AST_RX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R6

    AST_READY_NEEDS_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> link_up); // R8

    AST_DRIVE_HIGH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lnk_dat_oe) |-> lnk_dat_o); // R10

    AST_CLK_LOW_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !lnk_clk_oe |-> !lnk_clk_o); // R12
endmodule

bind sync_parity_xcvr sxc_checker #(.CLK_DIV(CLK_DIV)) u_sxc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_ready  (tx_ready),
    .link_up   (link_up),
    .rx_valid  (rx_valid),
    .lnk_clk_o (lnk_clk_o),
    .lnk_clk_oe(lnk_clk_oe),
    .lnk_dat_o (lnk_dat_o),
    .lnk_dat_oe(lnk_dat_oe)
);

// File: tb/sync_parity_xcvr_test.sv
`timescale 1ns/1ps
module sync_parity_xcvr_test;
    localparam int DIV   = 4;
    localparam int GUARD = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_req = 1'b0, dis_req = 1'b0, brk_req = 1'b0;
    logic       tx_valid = 1'b0, rx_req = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_ready, rx_valid, rx_err, link_up;
    logic [7:0] rx_data;
    logic       lnk_clk_o, lnk_clk_oe, lnk_dat_o, lnk_dat_oe, lnk_dat_i;
    logic       tgt_bit = 1'b1;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign lnk_dat_i = lnk_dat_oe ? lnk_dat_o : tgt_bit;

    sync_parity_xcvr #(.CLK_DIV(DIV), .GUARD_CYCLES(GUARD), .DATA_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .en_req(en_req), .dis_req(dis_req),
        .brk_req(brk_req), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .rx_req(rx_req), .rx_data(rx_data),
        .rx_valid(rx_valid), .rx_err(rx_err), .link_up(link_up),
        .lnk_clk_o(lnk_clk_o), .lnk_clk_oe(lnk_clk_oe),
        .lnk_dat_o(lnk_dat_o), .lnk_dat_oe(lnk_dat_oe), .lnk_dat_i(lnk_dat_i)
    );

    // Expected frame for a byte and expected error flag for a frame.
    function automatic logic [11:0] exp_frame(input logic [7:0] b);
        return {2'b11, ^b, b, 1'b0};
    endfunction
    function automatic logic exp_err(input logic [11:0] f);
        return ((^f[8:1]) != f[9]) || (f[11:10] != 2'b11);
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h (t=%0t)", req, act, expv, $time);
        end
    endtask

    // Far-end receiver: collects frames at link clock rises.
    int          mon_n = 0, mon_cnt = 0, ones_idle = 0;
    logic [11:0] mon_fr = '0, mon_frame = '0;
    always @(posedge lnk_clk_o) begin
        if (lnk_dat_oe) begin
            if (mon_n == 0) begin
                if (!lnk_dat_o) begin
                    mon_fr[0] = 1'b0;
                    mon_n = 1;
                end else begin
                    ones_idle++;
                end
            end else begin
                mon_fr[mon_n] = lnk_dat_o;
                mon_n++;
                if (mon_n == 12) begin
                    mon_frame = mon_fr;
                    mon_cnt++;
                    mon_n = 0;
                end
            end
        end
    end

    // Line timing monitors (R3 period, R4 change point) and receive capture.
    int   r3_bad = 0, r4_bad = 0, ntog = 0, last_tog = 0, rxv_cnt = 0, rxv_long = 0;
    logic tog_ok = 1'b0, p_do = 1'b0, p_oe = 1'b0, p_lc = 1'b0, p_rxv = 1'b0;
    logic [7:0] rx_got = '0;
    logic       rx_gerr = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (lnk_dat_oe && p_oe && (lnk_dat_o !== p_do) && !(p_lc && !lnk_clk_o)) r4_bad++;
            if (lnk_clk_o !== p_lc) begin
                if (lnk_clk_oe && tog_ok && ((cyc - last_tog) != DIV)) r3_bad++;
                last_tog = cyc;
                tog_ok   = lnk_clk_oe;
                ntog++;
            end
            if (!lnk_clk_oe) tog_ok = 1'b0;
            if (rx_valid) begin
                rx_got  = rx_data;
                rx_gerr = rx_err;
                rxv_cnt++;
                if (p_rxv) rxv_long++;
            end
        end
        p_do  = lnk_dat_o;
        p_oe  = lnk_dat_oe;
        p_lc  = lnk_clk_o;
        p_rxv = rx_valid;
    end

    task automatic wait_ready(input string req);
        int n = 0;
        @(negedge clk);
        while (!tx_ready && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check(tx_ready, req, tx_ready, 1);
    endtask

    task automatic do_enable();
        int hi = 0;
        int n  = 0;
        ones_idle = 0;
        mon_cnt   = 0;
        @(negedge clk) en_req = 1'b1;
        @(negedge clk) en_req = 1'b0;
        check(lnk_dat_o && lnk_dat_oe && lnk_clk_oe && !lnk_clk_o, "R11 preamble",
              {lnk_dat_o, lnk_dat_oe, lnk_clk_oe, lnk_clk_o}, 4'b1110);
        for (int i = 0; i < GUARD; i++) begin
            if (lnk_clk_o || !lnk_dat_o) hi++;
            @(negedge clk);
        end
        check(hi == 0, "R11 guard time", hi, 0);
        while (!link_up && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check(ones_idle >= 24 && mon_cnt == 0 && mon_n == 0, "R11 idle frames", ones_idle, 24);
        check(link_up && tx_ready, "R11 link up", {link_up, tx_ready}, 2'b11);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic turn);
        int n0;
        wait_ready("R8 ready before send");
        n0 = mon_cnt;
        tx_valid = 1'b1;
        tx_data  = b;
        @(negedge clk);
        tx_valid = 1'b0;
        check(!tx_ready, "R8 ready drops", tx_ready, 0);
        if (turn) begin
            check(lnk_dat_o && !lnk_dat_oe, "R10 data high before driver", {lnk_dat_o, lnk_dat_oe}, 2'b10);
            @(negedge clk);
            check(lnk_dat_o && lnk_dat_oe, "R10 driver on", {lnk_dat_o, lnk_dat_oe}, 2'b11);
        end
        wait_ready("R8 ready after send");
        check(mon_cnt == n0 + 1 && mon_frame == exp_frame(b), "R1 frame", mon_frame, exp_frame(b));
        check(mon_frame[9] == ^b, "R2 parity", mon_frame[9], ^b);
    endtask

    task automatic send_break();
        int n0, o0;
        wait_ready("R8 ready before break");
        n0 = mon_cnt;
        o0 = ones_idle;
        brk_req = 1'b1;
        @(negedge clk);
        brk_req = 1'b0;
        check(!tx_ready, "R7 ready low in break", tx_ready, 0);
        wait_ready("R7 ready after break");
        check(mon_cnt == n0 && mon_n == 0 && (ones_idle - o0) >= 12, "R7 break all ones",
              ones_idle - o0, 12);
    endtask

    task automatic recv_frame(input logic [11:0] f, input int idle);
        int n0;
        wait_ready("R8 ready before receive");
        n0 = rxv_cnt;
        rx_req = 1'b1;
        @(negedge clk);
        rx_req = 1'b0;
        check(!lnk_dat_oe && !lnk_dat_o, "R9 line released", {lnk_dat_oe, lnk_dat_o}, 0);
        for (int i = 0; i <= idle; i++) begin
            @(negedge lnk_clk_o) tgt_bit = 1'b1;
        end
        check(rxv_cnt == n0, "R5 high line ignored", rxv_cnt - n0, 0);
        for (int i = 0; i < 12; i++) begin
            @(negedge lnk_clk_o) tgt_bit = f[i];
        end
        @(negedge lnk_clk_o) tgt_bit = 1'b1;
        @(negedge clk);
        check(rxv_cnt == n0 + 1 && rx_got == f[8:1], "R5 received byte", rx_got, f[8:1]);
        check(rx_gerr == exp_err(f), "R6 error flag", rx_gerr, exp_err(f));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int unsigned seed_v;
        logic [7:0]  rb;
        int          t0;
        seed_v = $urandom(32'd20251);
        repeat (3) @(negedge clk);
        check(!tx_ready && !link_up && !lnk_clk_oe && !lnk_dat_oe && !lnk_clk_o && !lnk_dat_o && !rx_valid,
              "R12 reset state", {tx_ready, link_up, lnk_clk_oe, lnk_dat_oe, lnk_clk_o, lnk_dat_o}, 0);
        rst_n = 1'b1;
        // R8: send request before link is up is ignored
        tx_valid = 1'b1;
        tx_data  = 8'h5A;
        repeat (10) @(negedge clk);
        check(!tx_ready && !lnk_dat_oe && !lnk_clk_o, "R8 no send while down", tx_ready, 0);
        tx_valid = 1'b0;
        do_enable();
        // R3: clock keeps running while idle
        t0 = ntog;
        repeat (10 * DIV) @(negedge clk);
        check((ntog - t0) >= 9, "R3 idle toggling", ntog - t0, 10);
        // directed and random transmit (R1, R2)
        send_byte(8'h00, 1'b0);
        send_byte(8'hFF, 1'b0);
        send_byte(8'h01, 1'b0);
        send_byte(8'h80, 1'b0);
        for (int i = 0; i < 16; i++) begin
            send_byte(8'($urandom), 1'b0);
        end
        send_break();
        // receive after transmit (R9, R5, R6), then turnaround back (R10)
        recv_frame(exp_frame(8'hA5), 0);
        send_byte(8'h3C, 1'b1);
        for (int i = 0; i < 8; i++) begin
            rb = 8'($urandom);
            recv_frame(exp_frame(rb), int'($urandom % 4));
        end
        recv_frame(exp_frame(8'h6E) ^ 12'h200, 2);   // R6 parity bit wrong
        recv_frame(exp_frame(8'h11) & ~12'h400, 1);  // R6 first stop bit low
        recv_frame(exp_frame(8'hC3) & ~12'h800, 0);  // R6 second stop bit low
        check(rxv_long == 0, "R6 valid one cycle", rxv_long, 0);
        send_byte(8'h96, 1'b1);
        send_break();
        // disable (R12)
        wait_ready("R12 ready before disable");
        dis_req = 1'b1;
        @(negedge clk);
        dis_req = 1'b0;
        check(!lnk_clk_o && !lnk_clk_oe && !lnk_dat_o && !lnk_dat_oe && !link_up && !tx_ready,
              "R12 released", {lnk_clk_o, lnk_clk_oe, lnk_dat_o, lnk_dat_oe, link_up}, 0);
        t0 = ntog;
        repeat (6 * DIV) @(negedge clk);
        check(ntog == t0 && !lnk_clk_o, "R12 clock stopped", ntog - t0, 0);
        do_enable();
        send_byte(8'h27, 1'b0);
        check(r3_bad == 0, "R3 period", r3_bad, 0);
        check(r4_bad == 0, "R4 change on fall", r4_bad, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule